// File: doc/BRIEF.md
# Auto-precharge DRAM command sequencer

This block drives the command side of an already initialized four-bank DDR SDRAM and handles exactly one system request at a time. A request is either a refresh or a single burst access. Every access opens its row with ACTIVE. After the row-to-column delay it issues READ or WRITE with address bit 10 set, so the row closes by itself once the burst ends. Because every row is closed again, each access takes a fixed number of clocks and may land anywhere in the address space.

The sequencer exposes its state code so that a separate datapath can follow it. It also provides a read-data window and a write-data window. Commands, bank and address are registered, so each memory command reaches the pins one clock after the sequencer enters the state that issues it. Refresh uses a level request/acknowledge handshake. While the acknowledge is high, any system access request is ignored.

Top module: `dram_ap_seq`

## Requirements
- R1: After reset, state_o is 0 (idle), cmd_o is NOP (3'b111), the address, bank and the ref_ack_o, rd_en_o and wr_en_o outputs are 0. While init_done_i is low the block stays idle and issues only NOP, whatever the strobe and the refresh request do.
- R2: In idle with init_done_i high, a high ref_req_i moves the state to 9 (auto-refresh) on the next edge, even if ads_ni is low. A low ads_ni with ref_req_i low moves the state to 1 (active) instead, and bank, row and column are captured on that same edge.
- R3: cmd_o carries {ras_n, cas_n, we_n}: NOP 111, ACTIVE 011, READ 101, WRITE 100, AUTO REFRESH 001. Each command appears exactly one clock after the state enters 1, 3, 6 or 9 respectively, and NOP appears on every other clock.
- R4: ACTIVE drives the captured bank on ddr_ba_o and the captured row, zero-extended, on ddr_addr_o. READ and WRITE drive the bank and the column with bit 10 forced to 1: column bits 0..9 go to address bits 0..9, and any higher column bits go above bit 10.
- R5: rd_wrn_i is sampled on the edge that leaves the row-to-column wait, which is the last clock in state 1 or 2. A high value selects state 3 (read command) and a low value selects state 6 (write command).
- R6: A read passes through states 1, then 2 for T_RCD_CK-1 clocks, then 3, then 4 for cas_lat_i clocks (a value of 0 counts as 1), then 5 for the burst clocks, then returns to 0. burst_sel_i codes 0, 1 and 2/3 give 2, 4 and 8 clocks. With defaults, CAS latency 2 and burst 4, a read spans 10 clocks, counting the idle clock that samples the strobe.
- R7: A write passes through states 1, then 2 for T_RCD_CK-1 clocks, then 6, then 7 for the burst clocks, then 8 for T_DAL_CK-1 clocks with NOP only, then returns to 0. With defaults and burst 4, a write spans 9 clocks.
- R8: rd_en_o is high for the burst clocks starting cas_lat_i clocks after READ appears on cmd_o. wr_en_o is high for the burst clocks starting one clock after WRITE appears on cmd_o.
- R9: A refresh passes through state 9, then state 10 for T_RFC_CK-1 clocks, then returns to idle. AUTO REFRESH is issued once, and ref_ack_o is high in every clock of states 9 and 10.
- R10: A low ads_ni while ref_ack_o is high starts no access: no ACTIVE is issued, and the block is idle once the refresh completes.
- R11: If ref_req_i is still high when the block returns to idle after a refresh, the next edge starts another refresh.
- R12: A timing parameter of 1 removes its wait state completely: states 2, 8 or 10 are skipped and the path goes straight on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Memory initialization complete |
| ads_ni | input | 1 | Access strobe, active low |
| rd_wrn_i | input | 1 | 1 = read, 0 = write, sampled late |
| ref_req_i | input | 1 | Refresh request level |
| bank_i | input | BA_W | Bank of the access |
| row_i | input | ROW_W | Row of the access |
| col_i | input | COL_W | Starting column |
| burst_sel_i | input | 2 | Burst length code |
| cas_lat_i | input | 2 | CAS latency in clocks |
| state_o | output | 4 | Sequencer state code |
| cmd_o | output | 3 | {ras_n, cas_n, we_n} |
| ddr_ba_o | output | BA_W | Registered bank address |
| ddr_addr_o | output | ADDR_W | Registered row/column address |
| ref_ack_o | output | 1 | Refresh acknowledge |
| rd_en_o | output | 1 | Read data window |
| wr_en_o | output | 1 | Write data window |

## Verification
The assertions check the local rules on every clock. They check that no state leaves idle before init is done, that refresh has priority, that each command appears one clock after its state, that bit 10 is set with every READ and WRITE, that the branch taken matches the late-sampled read/write flag, and that the write window opens one clock after WRITE. Whole-sequence properties are shown only by the bench scenarios. These are the exact state length for every CAS latency and burst code, the address capture on the strobe edge, a strobe arriving during a refresh, back-to-back refresh on a held request, and collapsed wait states.

// File: rtl/dram_ap_seq_pkg.sv
package dram_ap_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_ACT   = 4'd1,
    ST_RCD   = 4'd2,
    ST_RDA   = 4'd3,
    ST_CL    = 4'd4,
    ST_RDATA = 4'd5,
    ST_WRA   = 4'd6,
    ST_WDATA = 4'd7,
    ST_DAL   = 4'd8,
    ST_AR    = 4'd9,
    ST_RFC   = 4'd10
  } seq_state_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_ACT = 3'b011;
  localparam logic [2:0] CMD_RD  = 3'b101;
  localparam logic [2:0] CMD_WR  = 3'b100;
  localparam logic [2:0] CMD_REF = 3'b001;

  localparam int AP_BIT = 10;

  function automatic logic [3:0] burst_clocks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dram_ap_seq_fsm.sv
module dram_ap_seq_fsm
  import dram_ap_seq_pkg::*;
#(
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 10,
  parameter int T_RCD_CK = 2,
  parameter int T_DAL_CK = 2,
  parameter int T_RFC_CK = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             ads_ni,
  input  logic             rd_wrn_i,
  input  logic             ref_req_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       burst_sel_i,
  input  logic [1:0]       cas_lat_i,
  output seq_state_e       state_o,
  output logic [BA_W-1:0]  bank_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);

  localparam int RCD_WAIT = (T_RCD_CK > 1) ? T_RCD_CK - 1 : 0;
  localparam int DAL_WAIT = (T_DAL_CK > 1) ? T_DAL_CK - 1 : 0;
  localparam int RFC_WAIT = (T_RFC_CK > 1) ? T_RFC_CK - 1 : 0;
  localparam int MAX_A    = (RCD_WAIT > DAL_WAIT) ? RCD_WAIT : DAL_WAIT;
  localparam int MAX_B    = (RFC_WAIT > MAX_A) ? RFC_WAIT : MAX_A;
  localparam int CNT_MAX  = (MAX_B > 8) ? MAX_B : 8;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam bit HAS_RCD  = RCD_WAIT > 0;
  localparam bit HAS_DAL  = DAL_WAIT > 0;
  localparam bit HAS_RFC  = RFC_WAIT > 0;
  localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(HAS_RCD ? RCD_WAIT - 1 : 0);
  localparam logic [CNT_W-1:0] DAL_LOAD = CNT_W'(HAS_DAL ? DAL_WAIT - 1 : 0);
  localparam logic [CNT_W-1:0] RFC_LOAD = CNT_W'(HAS_RFC ? RFC_WAIT - 1 : 0);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       cas_eff;
  logic [CNT_W-1:0] cl_load, bl_load;
  logic             cnt_zero, start;

  assign cas_eff  = (cas_lat_i == 2'd0) ? 2'd1 : cas_lat_i;
  assign cl_load  = CNT_W'(cas_eff - 2'd1);
  assign bl_load  = CNT_W'(burst_clocks(burst_sel_i) - 4'd1);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (init_done_i) begin
          if (ref_req_i)    state_d = ST_AR;
          else if (!ads_ni) state_d = ST_ACT;
        end
      end
      ST_ACT: begin
        if (HAS_RCD) begin
          state_d = ST_RCD;
          cnt_d   = RCD_LOAD;
        end else begin
          state_d = rd_wrn_i ? ST_RDA : ST_WRA;
        end
      end
      ST_RCD: begin
        if (cnt_zero) state_d = rd_wrn_i ? ST_RDA : ST_WRA;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_RDA: begin
        state_d = ST_CL;
        cnt_d   = cl_load;
      end
      ST_CL: begin
        if (cnt_zero) begin
          state_d = ST_RDATA;
          cnt_d   = bl_load;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_RDATA: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_WRA: begin
        state_d = ST_WDATA;
        cnt_d   = bl_load;
      end
      ST_WDATA: begin
        if (cnt_zero) begin
          if (HAS_DAL) begin
            state_d = ST_DAL;
            cnt_d   = DAL_LOAD;
          end else state_d = ST_IDLE;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_DAL: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_AR: begin
        if (HAS_RFC) begin
          state_d = ST_RFC;
          cnt_d   = RFC_LOAD;
        end else state_d = ST_IDLE;
      end
      ST_RFC: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign start = (state_q == ST_IDLE) && (state_d == ST_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // address is captured on the strobe edge only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
      row_o  <= '0;
      col_o  <= '0;
    end else if (start) begin
      bank_o <= bank_i;
      row_o  <= row_i;
      col_o  <= col_i;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dram_ap_seq_pins.sv
module dram_ap_seq_pins
  import dram_ap_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ref_ack_o,
  output logic              rd_en_o,
  output logic              wr_en_o
);

  logic [ADDR_W-1:0] col_addr;
  logic [ADDR_W-1:0] row_addr;

  // column bits skip the auto-precharge position
  for (genvar i = 0; i < ADDR_W; i++) begin : g_col
    if (i == AP_BIT) begin : g_ap
      assign col_addr[i] = 1'b1;
    end else if (i < AP_BIT) begin : g_lo
      if (i < COL_W) begin : g_use
        assign col_addr[i] = col_i[i];
      end else begin : g_pad
        assign col_addr[i] = 1'b0;
      end
    end else begin : g_hi
      if (i - 1 < COL_W) begin : g_use
        assign col_addr[i] = col_i[i-1];
      end else begin : g_pad
        assign col_addr[i] = 1'b0;
      end
    end
  end

  assign row_addr = ADDR_W'(row_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= CMD_NOP;
      ba_o    <= '0;
      addr_o  <= '0;
      wr_en_o <= 1'b0;
    end else begin
      wr_en_o <= (state_i == ST_WDATA);
      unique case (state_i)
        ST_ACT: begin
          cmd_o  <= CMD_ACT;
          ba_o   <= bank_i;
          addr_o <= row_addr;
        end
        ST_RDA: begin
          cmd_o  <= CMD_RD;
          ba_o   <= bank_i;
          addr_o <= col_addr;
        end
        ST_WRA: begin
          cmd_o  <= CMD_WR;
          ba_o   <= bank_i;
          addr_o <= col_addr;
        end
        ST_AR: begin
          cmd_o  <= CMD_REF;
          ba_o   <= '0;
          addr_o <= '0;
        end
        default: begin
          cmd_o  <= CMD_NOP;
          ba_o   <= '0;
          addr_o <= '0;
        end
      endcase
    end
  end

  assign rd_en_o   = (state_i == ST_RDATA);
  assign ref_ack_o = (state_i == ST_AR) || (state_i == ST_RFC);

endmodule

// File: rtl/dram_ap_seq.sv
module dram_ap_seq
  import dram_ap_seq_pkg::*;
#(
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 13,
  parameter int T_RCD_CK = 2,
  parameter int T_DAL_CK = 2,
  parameter int T_RFC_CK = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              ads_ni,
  input  logic              rd_wrn_i,
  input  logic              ref_req_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [1:0]        burst_sel_i,
  input  logic [1:0]        cas_lat_i,
  output logic [3:0]        state_o,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ddr_ba_o,
  output logic [ADDR_W-1:0] ddr_addr_o,
  output logic              ref_ack_o,
  output logic              rd_en_o,
  output logic              wr_en_o
);

  seq_state_e       state;
  logic [BA_W-1:0]  bank_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  dram_ap_seq_fsm #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RCD_CK(T_RCD_CK), .T_DAL_CK(T_DAL_CK), .T_RFC_CK(T_RFC_CK)
  ) i_fsm (
    .clk_i, .rst_ni, .init_done_i, .ads_ni, .rd_wrn_i, .ref_req_i,
    .bank_i, .row_i, .col_i, .burst_sel_i, .cas_lat_i,
    .state_o(state), .bank_o(bank_q), .row_o(row_q), .col_o(col_q)
  );

  dram_ap_seq_pins #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
  ) i_pins (
    .clk_i, .rst_ni, .state_i(state),
    .bank_i(bank_q), .row_i(row_q), .col_i(col_q),
    .cmd_o, .ba_o(ddr_ba_o), .addr_o(ddr_addr_o),
    .ref_ack_o, .rd_en_o, .wr_en_o
  );

  assign state_o = state;

endmodule

// File: rtl/dram_ap_seq_chk.sv
module dram_ap_seq_chk
  import dram_ap_seq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_done_i,
  input logic              ads_ni,
  input logic              rd_wrn_i,
  input logic              ref_req_i,
  input logic [3:0]        state_o,
  input logic [2:0]        cmd_o,
  input logic [ADDR_W-1:0] ddr_addr_o,
  input logic              ref_ack_o,
  input logic              rd_en_o,
  input logic              wr_en_o
);

  a_r1_idle_until_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && !init_done_i) |=> state_o == ST_IDLE);

  a_r2_refresh_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && init_done_i && ref_req_i) |=> state_o == ST_AR);

  a_r2_access_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && init_done_i && !ref_req_i && !ads_ni) |=> state_o == ST_ACT);

  a_r3_act_on_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ACT) |=> cmd_o == CMD_ACT);

  a_r4_ap_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> ddr_addr_o[AP_BIT]);

  a_r5_read_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RDA) |-> $past(rd_wrn_i));

  a_r5_write_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_WRA) |-> !$past(rd_wrn_i));

  a_r8_write_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(cmd_o) == CMD_WR);

  a_r8_one_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_o && wr_en_o));

  a_r9_refresh_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_ack_o) |=> cmd_o == CMD_REF);

  a_r10_no_act_in_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o |-> cmd_o != CMD_ACT);

endmodule

bind dram_ap_seq dram_ap_seq_chk #(.ADDR_W(ADDR_W)) i_dram_ap_seq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_done_i(init_done_i), .ads_ni(ads_ni),
  .rd_wrn_i(rd_wrn_i), .ref_req_i(ref_req_i), .state_o(state_o), .cmd_o(cmd_o),
  .ddr_addr_o(ddr_addr_o), .ref_ack_o(ref_ack_o), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o)
);

// File: tb/test_dram_ap_seq.sv
module test_dram_ap_seq;

  localparam int TR = 24;
  localparam int RCDW_A = 1, DW_A = 1, RFW_A = 7;
  localparam int RCDW_B = 0, DW_B = 0, RFW_B = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0, ads_n = 1'b1, rd_wrn = 1'b0, ref_req = 1'b0;
  logic [1:0] bank = '0;
  logic [12:0] row = '0;
  logic [9:0] col = '0;
  logic [1:0] burst_sel = 2'd1, cas_lat = 2'd2;

  logic [3:0] st_a, st_b;
  logic [2:0] cmd_a, cmd_b;
  logic [1:0] ba_a, ba_b;
  logic [12:0] addr_a, addr_b;
  logic ack_a, ack_b, rd_a, rd_b, wr_a, wr_b;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  int tr_st[2][TR], tr_cmd[2][TR], tr_ad[2][TR], tr_ack[2][TR], tr_rd[2][TR], tr_wr[2][TR];
  int rw_edge[TR + 1];

  always #2 clk = ~clk;

  dram_ap_seq i_dram_ap_seq (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .ads_ni(ads_n),
    .rd_wrn_i(rd_wrn), .ref_req_i(ref_req), .bank_i(bank), .row_i(row), .col_i(col),
    .burst_sel_i(burst_sel), .cas_lat_i(cas_lat), .state_o(st_a), .cmd_o(cmd_a),
    .ddr_ba_o(ba_a), .ddr_addr_o(addr_a), .ref_ack_o(ack_a), .rd_en_o(rd_a), .wr_en_o(wr_a)
  );

  dram_ap_seq #(.T_RCD_CK(1), .T_DAL_CK(1), .T_RFC_CK(1)) i_dram_ap_seq_min (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .ads_ni(ads_n),
    .rd_wrn_i(rd_wrn), .ref_req_i(ref_req), .bank_i(bank), .row_i(row), .col_i(col),
    .burst_sel_i(burst_sel), .cas_lat_i(cas_lat), .state_o(st_b), .cmd_o(cmd_b),
    .ddr_ba_o(ba_b), .ddr_addr_o(addr_b), .ref_ack_o(ack_b), .rd_en_o(rd_b), .wr_en_o(wr_b)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  function automatic int exp_state(int idx, int rd, int rcdw, int dw, int c, int b);
    int k;
    if (idx == 0) return 1;
    k = idx - 1;
    if (k < rcdw) return 2;
    k -= rcdw;
    if (k == 0) return rd ? 3 : 6;
    k -= 1;
    if (rd) begin
      if (k < c) return 4;
      k -= c;
      if (k < b) return 5;
      return 0;
    end
    if (k < b) return 7;
    k -= b;
    if (k < dw) return 8;
    return 0;
  endfunction

  function automatic int cmd_of(int s);
    case (s)
      1: return 3;
      3: return 5;
      6: return 4;
      9: return 1;
      default: return 7;
    endcase
  endfunction

  // Drives e0 inputs (caller is at a negedge), then records TR samples.
  task automatic capture(input int ads_edges, input int ref_edges, input int rw_v);
    ads_n = !(ads_edges > 0);
    ref_req = (ref_edges > 0);
    rd_wrn = !rw_v[0];
    rw_edge[0] = !rw_v;
    for (int j = 0; j < TR; j++) begin
      @(posedge clk);
      @(negedge clk);
      tr_st[0][j] = st_a;  tr_cmd[0][j] = cmd_a; tr_ad[0][j] = {ba_a, addr_a};
      tr_ack[0][j] = ack_a; tr_rd[0][j] = rd_a; tr_wr[0][j] = wr_a;
      tr_st[1][j] = st_b;  tr_cmd[1][j] = cmd_b; tr_ad[1][j] = {ba_b, addr_b};
      tr_ack[1][j] = ack_b; tr_rd[1][j] = rd_b; tr_wr[1][j] = wr_b;
      ads_n = !(j + 1 < ads_edges);
      ref_req = (j + 1 < ref_edges);
      rd_wrn = (j + 1 < 2) ? !rw_v[0] : rw_v[0];
      rw_edge[j+1] = rd_wrn;
      bank = ~bank; row = ~row; col = ~col;
    end
  endtask

  task automatic idle_clocks(input int n);
    ads_n = 1'b1; ref_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_access(input int inst, input int c, input int b,
                              input int bk, input int rw0, input int cl0);
    int rcdw, dw, rd, fj, g, e, n;
    rcdw = inst ? RCDW_B : RCDW_A;
    dw   = inst ? DW_B : DW_A;
    rd   = rw_edge[rcdw + 1];
    chk("R5", $sformatf("inst%0d branch state", inst), tr_st[inst][rcdw+1], rd ? 3 : 6);
    fj = -1;
    for (int j = 0; j < TR; j++)
      if (fj < 0 && tr_st[inst][j] != exp_state(j, rd, rcdw, dw, c, b)) fj = j;
    g = (fj < 0) ? 0 : tr_st[inst][fj];
    e = (fj < 0) ? 0 : exp_state(fj, rd, rcdw, dw, c, b);
    chk(inst ? "R12" : (rd ? "R6" : "R7"), $sformatf("state at clock %0d", fj), g, e);
    fj = -1;
    for (int j = 0; j < TR; j++)
      if (fj < 0 && tr_cmd[inst][j] != (j == 0 ? 7 : cmd_of(exp_state(j-1, rd, rcdw, dw, c, b)))) fj = j;
    g = (fj < 0) ? 0 : tr_cmd[inst][fj];
    e = (fj < 0) ? 0 : (fj == 0 ? 7 : cmd_of(exp_state(fj-1, rd, rcdw, dw, c, b)));
    chk("R3", $sformatf("inst%0d cmd at clock %0d", inst, fj), g, e);
    fj = -1; g = 0; e = 0;
    for (int j = 1; j < TR; j++) begin
      int p, x;
      p = exp_state(j-1, rd, rcdw, dw, c, b);
      x = -1;
      if (p == 1) x = bk * 8192 + rw0;
      else if (p == 3 || p == 6) x = bk * 8192 + 1024 + cl0;
      if (fj < 0 && x >= 0 && tr_ad[inst][j] != x) begin fj = j; g = tr_ad[inst][j]; e = x; end
    end
    chk("R4", $sformatf("inst%0d bank/addr at clock %0d", inst, fj), g, e);
    fj = -1; g = 0; e = 0;
    for (int j = 0; j < TR; j++) begin
      int er, ew;
      er = (exp_state(j, rd, rcdw, dw, c, b) == 5);
      ew = (j > 0 && exp_state(j-1, rd, rcdw, dw, c, b) == 7);
      if (fj < 0 && (tr_rd[inst][j] != er || tr_wr[inst][j] != ew)) begin
        fj = j; g = tr_rd[inst][j] * 2 + tr_wr[inst][j]; e = er * 2 + ew;
      end
    end
    chk("R8", $sformatf("inst%0d {rd_en,wr_en} at clock %0d", inst, fj), g, e);
    if (inst == 0 && c == 2 && b == 4) begin
      n = 1;
      for (int j = 0; j < TR; j++) if (tr_st[0][j] != 0) n++;
      chk(rd ? "R6" : "R7", "cycle length", n, rd ? 10 : 9);
    end
  endtask

  task automatic check_refresh(input int inst, input int upto, input string req);
    int rfw, fj, g, e;
    rfw = inst ? RFW_B : RFW_A;
    fj = -1; g = 0; e = 0;
    for (int j = 0; j < upto; j++) begin
      int es, ec;
      es = (j == 0) ? 9 : ((j <= rfw) ? 10 : 0);
      ec = (j == 1) ? 1 : 7;
      if (fj < 0 && (tr_st[inst][j] != es || tr_ack[inst][j] != (j <= rfw) || tr_cmd[inst][j] != ec)) begin
        fj = j; g = tr_st[inst][j] * 100 + tr_ack[inst][j] * 10 + tr_cmd[inst][j];
        e = es * 100 + (j <= rfw) * 10 + ec;
      end
    end
    chk(req, $sformatf("inst%0d state*100+ack*10+cmd at clock %0d", inst, fj), g, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "state after reset", st_a, 0);
    chk("R1", "cmd after reset", cmd_a, 7);
    chk("R1", "ba/addr after reset", {ba_a, addr_a}, 0);
    chk("R1", "ack/rd/wr after reset", {ack_a, rd_a, wr_a}, 0);
    // R1 hold while init low
    ads_n = 1'b0; ref_req = 1'b1;
    begin
      int bad;
      bad = 0;
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        if (st_a != 0 || st_b != 0 || cmd_a != 7 || cmd_b != 7 || ack_a || ack_b) bad++;
      end
      chk("R1", "non-idle clocks before init", bad, 0);
    end
    ads_n = 1'b1; ref_req = 1'b0; init_done = 1'b1;
    @(negedge clk);

    // access sweep: R3..R8, R12
    k = 0;
    for (int c = 0; c < 4; c++)
      for (int bs = 0; bs < 4; bs++)
        for (int v = 0; v < 2; v++) begin
          int bk, rw0, cl0, ce, b;
          bk = k % 4; rw0 = (k * 997 + 5) % 8192; cl0 = (k * 131 + 3) % 1024;
          ce = (c == 0) ? 1 : c;
          b = (bs == 0) ? 2 : ((bs == 1) ? 4 : 8);
          cas_lat = c[1:0]; burst_sel = bs[1:0];
          bank = bk[1:0]; row = rw0[12:0]; col = cl0[9:0];
          capture(1, 0, v);
          check_access(0, ce, b, bk, rw0, cl0);
          check_access(1, ce, b, bk, rw0, cl0);
          idle_clocks(2);
          k++;
        end
    cas_lat = 2'd2; burst_sel = 2'd1;

    // R9 plain refresh, both instances
    capture(0, 1, 0);
    check_refresh(0, TR, "R9");
    check_refresh(1, TR, "R12");
    idle_clocks(2);

    // R2 priority and R10 strobe ignored during refresh
    capture(RFW_A + 2, 1, 1);
    chk("R2", "refresh wins over strobe", tr_st[0][0], 9);
    check_refresh(0, TR, "R10");
    idle_clocks(TR + 4);

    // R11 held request repeats the refresh
    capture(0, RFW_A + 3, 0);
    chk("R11", "idle between refreshes", tr_st[0][RFW_A+1], 0);
    chk("R11", "ack low between refreshes", tr_ack[0][RFW_A+1], 0);
    chk("R11", "second refresh starts", tr_st[0][RFW_A+2], 9);
    chk("R11", "second refresh command", tr_cmd[0][RFW_A+3], 1);
    idle_clocks(TR + 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule